// File: doc/BRIEF.md
# Interlaced Video Timing Generator

This block produces raster timing for a display pipeline, one pixel per clock. Two counters walk across each line and down each field. From their positions the block derives horizontal sync, vertical sync, a composite sync and a data-enable. It also emits a one-cycle pulse at the start of every field and another when vertical sync begins. Positions are counted from the top-left pixel of the visible region. Pixel (0, 0) is the first active pixel, and the porches and sync pulses follow the active area on each line and below it in each field.

Software loads timing through a small write-only configuration port into staging registers. These registers are copied into a working shadow set only as the last pixel of a field passes, so every field runs with one consistent set of values. In interlaced mode the generator alternates even and odd fields. The odd field carries one extra line, placed in its vertical back porch, and its vertical sync edges sit mid-line, half a line total before the horizontal sync start. The vertical front porch is identical in both fields. In progressive mode every field uses the even-field parameters and the field flag stays low.

Top module: `ilace_timing_gen`

## Requirements
- R1: While reset is high and on the first clock after it, every output is low and the reported position is (0, 0). The first cycle after reset shows a field-start pulse with the field flag low.
- R2: On each line, with line total HT, active width HA, front porch HF and back porch HB, horizontal sync is active for pixels HA+HF through HT-HB-1.
- R3: Data-enable is high exactly when the pixel is below the active width and the line is below the active height.
- R4: In progressive mode every field has VT lines. Vertical sync rises at line VA+VF, pixel HA+HF, and falls at line VT-VB, same pixel.
- R5: The pixel counter runs 0..HT-1 and then advances the line. After the last line the line counter returns to 0. In interlaced mode the field flag then toggles, and the odd field (flag 1) has VT+1 lines. The flag is low after reset and changes only at a field boundary.
- R6: In the odd field, vertical sync rises at line VA+VF and falls at line VT-VB. Both edges occur at pixel HA+HF-HT/2 (HT/2 truncated). This keeps the front porch the same and makes the back porch one line longer. The design assumes HA+HF is at least HT/2.
- R7: The vertical-sync event output pulses for exactly one cycle, in the cycle that vertical sync becomes active. The reported position and field flag identify that edge.
- R8: The field-start output pulses for one cycle at position (0, 0) of every field and at no other position.
- R9: Sync outputs are active high by default. Control bits 1, 2 and 3 invert horizontal, vertical and composite sync respectively. Composite sync is the OR of the active horizontal and vertical syncs before inversion.
- R10: A configuration write changes nothing in the field in progress. The written value governs every field that starts after the write.
- R11: Configuration is written at word addresses, with vertical values in bits 31:16 and horizontal values in bits 15:0. Address 0 holds the active size, address 1 the totals, address 2 the horizontal back porch (high half) and front porch (low half), and address 3 the vertical back porch (high) and front porch (low). Address 4 is control: bit 0 selects interlace and bits 1–3 are the inverts. Writes to addresses 5–7 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| hsync_o | output | 1 | Horizontal sync, polarity per control |
| vsync_o | output | 1 | Vertical sync, polarity per control |
| csync_o | output | 1 | Composite sync, polarity per control |
| de_o | output | 1 | Data-enable for the active region |
| field_odd_o | output | 1 | High during the odd field |
| frame_start_o | output | 1 | One-cycle pulse at the first pixel of a field |
| vsync_evt_o | output | 1 | One-cycle pulse at the vertical sync leading edge |
| pix_x_o | output | 16 | Pixel position of the current outputs |
| line_y_o | output | 16 | Line position of the current outputs |

## Verification
The hardest situations to reach are the field boundary as seen by a configuration change, and the half-line shift of the odd field. Both appear only after whole fields have run. The stimulus writes new timing while a field is in progress, then holds it across several field boundaries. It does this with progressive timing, with interlaced timing, with inverted polarities, and when switching from interlaced back to progressive while the odd field is running. A position-based reference checks every cycle. Expected vertical-sync events are queued at each field start and must be matched by position and field.

// File: rtl/ilace_pkg.sv
package ilace_pkg;
  localparam int CW = 16;
  localparam int DW = 2 * CW;
  localparam int AW = 3;

  typedef logic [CW-1:0] crd_t;

  // working timing set
  typedef struct packed {
    crd_t hact;
    crd_t vact;
    crd_t htot;
    crd_t vtot;
    crd_t hfp;
    crd_t hbp;
    crd_t vfp;
    crd_t vbp;
    logic ilace;
    logic inv_h;
    logic inv_v;
    logic inv_c;
  } tcfg_t;

  // vertical sync placement for one field
  typedef struct packed {
    crd_t vs_start;
    crd_t vs_end;
    crd_t vs_pix;
  } fparm_t;

  localparam logic [AW-1:0] ADR_ACTIVE = 3'd0;
  localparam logic [AW-1:0] ADR_TOTAL  = 3'd1;
  localparam logic [AW-1:0] ADR_HPORCH = 3'd2;
  localparam logic [AW-1:0] ADR_VPORCH = 3'd3;
  localparam logic [AW-1:0] ADR_CTRL   = 3'd4;
endpackage

// File: rtl/ilace_cfg_regs.sv
module ilace_cfg_regs
  import ilace_pkg::*;
#(
  parameter tcfg_t RST_CFG = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          field_end,
  output tcfg_t         shadow_o,
  output logic          nxt_ilace_o
);
  tcfg_t stage;

  // staging bank: accepts writes at any time
  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= RST_CFG;
    end else if (cfg_we) begin
      case (cfg_addr)
        ADR_ACTIVE: begin
          stage.vact <= cfg_wdata[DW-1:CW];
          stage.hact <= cfg_wdata[CW-1:0];
        end
        ADR_TOTAL: begin
          stage.vtot <= cfg_wdata[DW-1:CW];
          stage.htot <= cfg_wdata[CW-1:0];
        end
        ADR_HPORCH: begin
          stage.hbp <= cfg_wdata[DW-1:CW];
          stage.hfp <= cfg_wdata[CW-1:0];
        end
        ADR_VPORCH: begin
          stage.vbp <= cfg_wdata[DW-1:CW];
          stage.vfp <= cfg_wdata[CW-1:0];
        end
        ADR_CTRL: begin
          stage.ilace <= cfg_wdata[0];
          stage.inv_h <= cfg_wdata[1];
          stage.inv_v <= cfg_wdata[2];
          stage.inv_c <= cfg_wdata[3];
        end
        default: ;
      endcase
    end
  end

  // shadow bank: copied only as a field ends
  always_ff @(posedge clk) begin
    if (rst) shadow_o <= RST_CFG;
    else if (field_end) shadow_o <= stage;
  end

  assign nxt_ilace_o = stage.ilace;

  // R10: the working set never moves inside a field
  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !field_end |=> $stable(shadow_o));
endmodule

// File: rtl/ilace_field_calc.sv
module ilace_field_calc
  import ilace_pkg::*;
(
  input  tcfg_t          cfg,
  output crd_t           hs_start_o,
  output crd_t           hs_end_o,
  output crd_t   [1:0]   vtot_o,
  output fparm_t [1:0]   fld_o
);
  crd_t hs_start;
  crd_t half_line;

  assign hs_start   = cfg.hact + cfg.hfp;
  assign half_line  = cfg.htot >> 1;
  assign hs_start_o = hs_start;
  assign hs_end_o   = cfg.htot - cfg.hbp;

  // index 0 = even field, index 1 = odd field; odd collapses to even when progressive
  for (genvar g = 0; g < 2; g++) begin : g_fld
    logic   odd;
    crd_t   vt;
    fparm_t p;
    assign odd = (g == 1) && cfg.ilace;
    always_comb begin
      vt         = cfg.vtot + crd_t'(odd);
      p.vs_start = cfg.vact + cfg.vfp;
      p.vs_end   = vt - (cfg.vbp + crd_t'(odd));
      p.vs_pix   = odd ? (hs_start - half_line) : hs_start;
    end
    assign vtot_o[g] = vt;
    assign fld_o[g]  = p;
  end
endmodule

// File: rtl/ilace_counters.sv
module ilace_counters
  import ilace_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  crd_t        htot,
  input  crd_t [1:0]  vtot_f,
  input  logic        nxt_ilace,
  output crd_t        cnt_h,
  output crd_t        cnt_v,
  output logic        field_odd,
  output logic        field_end
);
  crd_t vt_cur;
  logic line_end;

  assign vt_cur    = vtot_f[field_odd];
  assign line_end  = cnt_h >= (htot - crd_t'(1));
  assign field_end = line_end && (cnt_v >= (vt_cur - crd_t'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_h     <= '0;
      cnt_v     <= '0;
      field_odd <= 1'b0;
    end else if (line_end) begin
      cnt_h <= '0;
      if (field_end) begin
        cnt_v     <= '0;
        field_odd <= nxt_ilace & ~field_odd;
      end else begin
        cnt_v <= cnt_v + crd_t'(1);
      end
    end else begin
      cnt_h <= cnt_h + crd_t'(1);
    end
  end

  // R5: pixel counter stays within the line
  a_r5_h_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_h < htot);
  // R5: field flag moves only at a boundary
  a_r5_field_hold: assert property (@(posedge clk) disable iff (rst)
    !field_end |=> $stable(field_odd));
  // R5: interlaced boundary flips the field
  a_r5_field_flip: assert property (@(posedge clk) disable iff (rst)
    (field_end && nxt_ilace) |=> (field_odd != $past(field_odd)));
endmodule

// File: rtl/ilace_sync_out.sv
module ilace_sync_out
  import ilace_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  crd_t          hact,
  input  crd_t          vact,
  input  crd_t          hs_start,
  input  crd_t          hs_end,
  input  fparm_t [1:0]  fld,
  input  logic          inv_h,
  input  logic          inv_v,
  input  logic          inv_c,
  input  crd_t          cnt_h,
  input  crd_t          cnt_v,
  input  logic          field_odd,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          csync_o,
  output logic          de_o,
  output logic          field_o,
  output logic          frame_o,
  output logic          vevt_o,
  output crd_t          x_o,
  output crd_t          y_o
);
  fparm_t f;
  logic   hs_act, vs_act, de_act, after_start, before_end, evt, org;
  logic   hs_raw_q, vs_raw_q;

  assign f           = fld[field_odd];
  assign hs_act      = (cnt_h >= hs_start) && (cnt_h < hs_end);
  assign after_start = (cnt_v > f.vs_start) || ((cnt_v == f.vs_start) && (cnt_h >= f.vs_pix));
  assign before_end  = (cnt_v < f.vs_end)   || ((cnt_v == f.vs_end)   && (cnt_h <  f.vs_pix));
  assign vs_act      = after_start && before_end;
  assign de_act      = (cnt_h < hact) && (cnt_v < vact);
  assign evt         = (cnt_v == f.vs_start) && (cnt_h == f.vs_pix);
  assign org         = (cnt_h == '0) && (cnt_v == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o  <= 1'b0;
      vsync_o  <= 1'b0;
      csync_o  <= 1'b0;
      de_o     <= 1'b0;
      field_o  <= 1'b0;
      frame_o  <= 1'b0;
      vevt_o   <= 1'b0;
      x_o      <= '0;
      y_o      <= '0;
      hs_raw_q <= 1'b0;
      vs_raw_q <= 1'b0;
    end else begin
      hsync_o  <= hs_act ^ inv_h;
      vsync_o  <= vs_act ^ inv_v;
      csync_o  <= (hs_act | vs_act) ^ inv_c;
      de_o     <= de_act;
      field_o  <= field_odd;
      frame_o  <= org;
      vevt_o   <= evt;
      x_o      <= cnt_h;
      y_o      <= cnt_v;
      hs_raw_q <= hs_act;
      vs_raw_q <= vs_act;
    end
  end

  // R3: no active data inside horizontal sync
  a_r3_de_not_in_hsync: assert property (@(posedge clk) disable iff (rst)
    de_o |-> !hs_raw_q);
  // R7: event marks the leading edge of vertical sync
  a_r7_evt_on_rise: assert property (@(posedge clk) disable iff (rst)
    vevt_o |-> (vs_raw_q && !$past(vs_raw_q)));
  // R7: event lasts one cycle
  a_r7_evt_single: assert property (@(posedge clk) disable iff (rst)
    vevt_o |=> !vevt_o);
  // R8: field start only at the origin
  a_r8_frame_origin: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> ((x_o == '0) && (y_o == '0)));
endmodule

// File: rtl/ilace_timing_gen.sv
module ilace_timing_gen
  import ilace_pkg::*;
#(
  parameter int DEF_HACT = 16,
  parameter int DEF_VACT = 8,
  parameter int DEF_HTOT = 24,
  parameter int DEF_VTOT = 13,
  parameter int DEF_HFP  = 2,
  parameter int DEF_HBP  = 3,
  parameter int DEF_VFP  = 1,
  parameter int DEF_VBP  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          csync_o,
  output logic          de_o,
  output logic          field_odd_o,
  output logic          frame_start_o,
  output logic          vsync_evt_o,
  output logic [CW-1:0] pix_x_o,
  output logic [CW-1:0] line_y_o
);
  localparam tcfg_t RST_CFG = '{
    hact: crd_t'(DEF_HACT), vact: crd_t'(DEF_VACT),
    htot: crd_t'(DEF_HTOT), vtot: crd_t'(DEF_VTOT),
    hfp:  crd_t'(DEF_HFP),  hbp:  crd_t'(DEF_HBP),
    vfp:  crd_t'(DEF_VFP),  vbp:  crd_t'(DEF_VBP),
    ilace: 1'b0, inv_h: 1'b0, inv_v: 1'b0, inv_c: 1'b0
  };

  tcfg_t        cfg;
  logic         nxt_ilace;
  logic         field_end;
  crd_t         hs_start, hs_end;
  crd_t   [1:0] vtot_f;
  fparm_t [1:0] fld;
  crd_t         cnt_h, cnt_v;
  logic         field_odd;

  ilace_cfg_regs #(.RST_CFG(RST_CFG)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .field_end(field_end),
    .shadow_o(cfg), .nxt_ilace_o(nxt_ilace)
  );

  ilace_field_calc u_calc (
    .cfg(cfg), .hs_start_o(hs_start), .hs_end_o(hs_end),
    .vtot_o(vtot_f), .fld_o(fld)
  );

  ilace_counters u_cnt (
    .clk(clk), .rst(rst), .htot(cfg.htot), .vtot_f(vtot_f),
    .nxt_ilace(nxt_ilace), .cnt_h(cnt_h), .cnt_v(cnt_v),
    .field_odd(field_odd), .field_end(field_end)
  );

  ilace_sync_out u_out (
    .clk(clk), .rst(rst), .hact(cfg.hact), .vact(cfg.vact),
    .hs_start(hs_start), .hs_end(hs_end), .fld(fld),
    .inv_h(cfg.inv_h), .inv_v(cfg.inv_v), .inv_c(cfg.inv_c),
    .cnt_h(cnt_h), .cnt_v(cnt_v), .field_odd(field_odd),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o),
    .de_o(de_o), .field_o(field_odd_o), .frame_o(frame_start_o),
    .vevt_o(vsync_evt_o), .x_o(pix_x_o), .y_o(line_y_o)
  );
endmodule

// File: tb/ilace_timing_gen_test.sv
module ilace_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic hsync_o, vsync_o, csync_o, de_o, field_odd_o, frame_start_o, vsync_evt_o;
  logic [15:0] pix_x_o, line_y_o;

  always #2 clk = ~clk;

  ilace_timing_gen uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o), .de_o(de_o),
    .field_odd_o(field_odd_o), .frame_start_o(frame_start_o), .vsync_evt_o(vsync_evt_o),
    .pix_x_o(pix_x_o), .line_y_o(line_y_o)
  );

  typedef struct {
    int hact, vact, htot, vtot, hfp, hbp, vfp, vbp;
    int il, ih, iv, ic;
  } mcfg_t;
  typedef struct { int x; int y; int f; } evt_t;

  mcfg_t stg, act;
  evt_t  evq[$];
  int nvec = 0, nerr = 0, nframes = 0;
  bit started = 0;
  int nx, ny, nf, nwrap, cyc, exp_len;

  task automatic chk(input bit ok, input string req, input int av, input int ev);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, av, ev);
    end
  endtask

  // driver side: expected vertical-sync event for a field just begun
  task automatic push_expect(input int f);
    evt_t e;
    int hss;
    hss = act.hact + act.hfp;
    e.x = (f != 0) ? hss - act.htot / 2 : hss;
    e.y = act.vact + act.vfp;
    e.f = f;
    evq.push_back(e);
  endtask

  // R11 register packing
  task automatic cfg_write(input int a, input int hi, input int lo);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[2:0]; cfg_wdata = {hi[15:0], lo[15:0]};
    case (a)
      0: begin stg.vact = hi; stg.hact = lo; end
      1: begin stg.vtot = hi; stg.htot = lo; end
      2: begin stg.hbp = hi; stg.hfp = lo; end
      3: begin stg.vbp = hi; stg.vfp = lo; end
      4: begin stg.il = lo & 1; stg.ih = (lo >> 1) & 1; stg.iv = (lo >> 2) & 1; stg.ic = (lo >> 3) & 1; end
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_fields(input int n);
    int target;
    target = nframes + n;
    while (nframes < target) @(negedge clk);
  endtask

  task automatic wait_mid();
    @(negedge clk);
    while (!(line_y_o == 16'd1 && pix_x_o == 16'd2)) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      int x, y, f, hss, hse, vt, vss, vse, vp;
      bit hs, vs, de;
      evt_t e;
      x = int'(pix_x_o); y = int'(line_y_o); f = int'(field_odd_o);
      if (started) begin
        chk(x == nx, "R5 pixel position", x, nx);
        chk(y == ny, "R5 line position", y, ny);
        chk(f == nf, "R5 field flag", f, nf);
        chk(int'(frame_start_o) == nwrap, "R8 field start pulse", int'(frame_start_o), nwrap);
      end
      if (frame_start_o) begin
        if (started) begin
          chk(cyc == exp_len, "R10 field length under old settings", cyc, exp_len);
          chk(evq.size() == 0, "R7 vertical sync event missing", evq.size(), 0);
          evq.delete();
        end else begin
          chk(x == 0 && y == 0 && f == 0, "R1 first field start", x + y + f, 0);
        end
        act = stg;
        started = 1;
        cyc = 0;
        exp_len = act.htot * (act.vtot + f);
        push_expect(f);
        nframes++;
      end
      if (started) begin
        hss = act.hact + act.hfp;
        hse = act.htot - act.hbp;
        vt  = act.vtot + f;
        vss = act.vact + act.vfp;
        vse = vt - (act.vbp + f);
        vp  = (f != 0) ? hss - act.htot / 2 : hss;
        hs  = (x >= hss) && (x < hse);
        vs  = ((y > vss) || (y == vss && x >= vp)) && ((y < vse) || (y == vse && x < vp));
        de  = (x < act.hact) && (y < act.vact);
        chk(de_o == de, "R3 data enable", int'(de_o), int'(de));
        chk(hsync_o == (hs ^ act.ih[0]), "R2 R9 horizontal sync", int'(hsync_o), int'(hs ^ act.ih[0]));
        if (f != 0) chk(vsync_o == (vs ^ act.iv[0]), "R6 odd field vertical sync", int'(vsync_o), int'(vs ^ act.iv[0]));
        else        chk(vsync_o == (vs ^ act.iv[0]), "R4 vertical sync", int'(vsync_o), int'(vs ^ act.iv[0]));
        chk(csync_o == ((hs | vs) ^ act.ic[0]), "R9 composite sync", int'(csync_o), int'((hs | vs) ^ act.ic[0]));
        if (vsync_evt_o) begin
          if (evq.size() == 0) chk(1'b0, "R7 unexpected vertical sync event", 1, 0);
          else begin
            e = evq.pop_front();
            chk(x == e.x, "R7 R6 event pixel", x, e.x);
            chk(y == e.y, "R7 event line", y, e.y);
            chk(f == e.f, "R7 event field", f, e.f);
          end
        end
        cyc++;
        if (x >= act.htot - 1) begin
          nx = 0;
          if (y >= vt - 1) begin
            ny = 0; nf = (stg.il != 0) ? 1 - f : 0; nwrap = 1;
          end else begin
            ny = y + 1; nf = f; nwrap = 0;
          end
        end else begin
          nx = x + 1; ny = y; nf = f; nwrap = 0;
        end
      end
    end
  end

  initial begin
    stg = '{hact:16, vact:8, htot:24, vtot:13, hfp:2, hbp:3, vfp:1, vbp:2, il:0, ih:0, iv:0, ic:0};
    act = stg;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!hsync_o && !vsync_o && !csync_o && !de_o, "R1 syncs and enable low", int'(hsync_o | vsync_o | csync_o | de_o), 0);
    chk(!frame_start_o && !vsync_evt_o && !field_odd_o, "R1 pulses low", int'(frame_start_o | vsync_evt_o | field_odd_o), 0);
    chk(pix_x_o == 0 && line_y_o == 0, "R1 position zero", int'(pix_x_o) + int'(line_y_o), 0);
    rst = 1'b0;
    wait_fields(2);

    // progressive set written mid-field (R4, R10, R11)
    wait_mid();
    cfg_write(0, 10, 20);
    cfg_write(1, 18, 32);
    cfg_write(2, 4, 3);
    cfg_write(3, 3, 2);
    cfg_write(6, 16'h00ff, 16'h00ff); // R11 unused address ignored
    wait_fields(3);

    // interlaced set (R5, R6, R7)
    wait_mid();
    cfg_write(0, 6, 24);
    cfg_write(1, 12, 40);
    cfg_write(2, 3, 10);
    cfg_write(3, 2, 2);
    cfg_write(4, 0, 1);
    wait_fields(4);

    // interlaced with all inverts (R9)
    wait_mid();
    cfg_write(4, 0, 15);
    cfg_write(7, 16'hffff, 16'hffff); // R11 ignored
    wait_fields(3);

    // back to progressive, inverted, switched inside the odd field (R5)
    while (field_odd_o != 1'b1) @(negedge clk);
    wait_mid();
    cfg_write(4, 0, 14);
    wait_fields(3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule